// File: doc/BRIEF.md
# Video Vertical Timing Generator

This block generates the vertical timing of an interlaced-style video field that is counted in half-lines. A 10-bit vertical counter advances once for every pulse of a 31.25 kHz half-line enable and wraps after 625 steps, so one field lasts 312.5 lines. The counter value is used to decode a five-step vertical sync pulse and an active-display window. The end of that window depends on whether the current screen mode is a graphics mode or a text mode.

Two interrupt sources come from the same count. A periodic real-time-clock tick fires once per field at half-line 200. A display-end event fires when the active window closes. Each source sets a sticky flag that stays high until the processor clears it with a per-bit strobe. A per-bit enable masks each flag onto a single active-high interrupt request. The enables gate only the request and leave the flags themselves untouched.

Top module: `vtg_vertical_timing`

## Requirements
- R1: `vcount_o` increments by one on a clock edge where `half_line_en_i` is high and holds its value on every edge where it is low.
- R2: `vcount_o` stays within 0 to 624; a step taken from 624 returns it to 0.
- R3: `vsync_o` is high exactly while `vcount_o` is in the range 564 to 568 inclusive, which is five half-lines.
- R4: `active_o` is high while `vcount_o` is below 512 with `gfx_mode_i`=1, and below 500 with `gfx_mode_i`=0. The mode input acts on the output without delay.
- R5: `rtc_flag_o` becomes set on the edge where `vcount_o` steps to 200.
- R6: `dend_flag_o` becomes set on the edge where `vcount_o` steps to 512 if `gfx_mode_i`=1, or to 500 if `gfx_mode_i`=0. The mode is the one present at that step.
- R7: Each flag holds until its clear strobe is high on a clock edge. Bit 0 of `irq_clr_i` clears `rtc_flag_o` and bit 1 clears `dend_flag_o`. If a set and a clear of the same flag fall on one edge, the set wins.
- R8: `irq_o` is high exactly when (`rtc_flag_o` and `irq_en_i[0]`) or (`dend_flag_o` and `irq_en_i[1]`). The enables never change the flags.
- R9: While `rst_ni` is low, `vcount_o`, both flags, `vsync_o` and `irq_o` are 0. `active_o` then follows R4 for count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_line_en_i | input | 1 | One-cycle enable per half-line period |
| gfx_mode_i | input | 1 | 1 = graphics mode, 0 = text mode |
| irq_en_i | input | 2 | Interrupt enables: bit 0 RTC, bit 1 display end |
| irq_clr_i | input | 2 | Flag clear strobes: bit 0 RTC, bit 1 display end |
| vsync_o | output | 1 | Vertical sync pulse |
| active_o | output | 1 | Active-display window |
| rtc_flag_o | output | 1 | Sticky RTC interrupt flag |
| dend_flag_o | output | 1 | Sticky display-end interrupt flag |
| irq_o | output | 1 | Masked interrupt request, active high |
| vcount_o | output | 10 | Vertical half-line count |

## Verification
The assertions check on every cycle that the count holds without an enable and wraps from 624 to 0. They also check that it never leaves its range, that sync only begins at 564, that stepping to 200 raises the RTC flag, that a clear without a coincident set drops the flag, and that the request is low when no enable is set. The exact sync width, the mode-dependent display-end point taken under a changing mode, the set-over-clear priority, and the full masked combination of flags only show up in the bench scenarios. Those scenarios compare every output each cycle against an independent model.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int SRC_RTC  = 0;
  localparam int SRC_DEND = 1;
  localparam int NUM_SRC  = 2;
endpackage

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int CNT_W     = 10,
  parameter int FRAME_LEN = 625
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SYNC_START = 564,
  parameter int SYNC_LEN   = 5,
  parameter int RTC_POS    = 200,
  parameter int GFX_END    = 512,
  parameter int TXT_END    = 500
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               step_i,
  input  logic               gfx_i,
  output logic               vsync_o,
  output logic               active_o,
  output logic [NUM_SRC-1:0] hit_o
);
  localparam logic [CNT_W-1:0] SYNC_LO  = CNT_W'(SYNC_START);
  localparam logic [CNT_W-1:0] SYNC_HI  = CNT_W'(SYNC_START + SYNC_LEN - 1);
  localparam logic [CNT_W-1:0] GFX_LIM  = CNT_W'(GFX_END);
  localparam logic [CNT_W-1:0] TXT_LIM  = CNT_W'(TXT_END);
  // events are decoded one count early so the flag rises with the count
  localparam logic [CNT_W-1:0] RTC_PRE  = CNT_W'(RTC_POS - 1);
  localparam logic [CNT_W-1:0] GFX_PRE  = CNT_W'(GFX_END - 1);
  localparam logic [CNT_W-1:0] TXT_PRE  = CNT_W'(TXT_END - 1);

  logic [CNT_W-1:0] end_lim, end_pre;

  assign end_lim  = gfx_i ? GFX_LIM : TXT_LIM;
  assign end_pre  = gfx_i ? GFX_PRE : TXT_PRE;
  assign vsync_o  = (cnt_i >= SYNC_LO) && (cnt_i <= SYNC_HI);
  assign active_o = cnt_i < end_lim;

  always_comb begin
    hit_o           = '0;
    hit_o[SRC_RTC]  = step_i && (cnt_i == RTC_PRE);
    hit_o[SRC_DEND] = step_i && (cnt_i == end_pre);
  end
endmodule

// File: rtl/vtg_irq.sv
module vtg_irq
  import vtg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hit_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] flag_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (hit_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/vtg_vertical_timing.sv
module vtg_vertical_timing
  import vtg_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int FRAME_LEN  = 625,
  parameter int SYNC_START = 564,
  parameter int SYNC_LEN   = 5,
  parameter int RTC_POS    = 200,
  parameter int GFX_END    = 512,
  parameter int TXT_END    = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_line_en_i,
  input  logic             gfx_mode_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       irq_clr_i,
  output logic             vsync_o,
  output logic             active_o,
  output logic             rtc_flag_o,
  output logic             dend_flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] vcount_o
);
  logic [CNT_W-1:0]   cnt;
  logic [NUM_SRC-1:0] hit, flag;

  vtg_counter #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (half_line_en_i),
    .cnt_o  (cnt)
  );

  vtg_decode #(
    .CNT_W(CNT_W), .SYNC_START(SYNC_START), .SYNC_LEN(SYNC_LEN),
    .RTC_POS(RTC_POS), .GFX_END(GFX_END), .TXT_END(TXT_END)
  ) i_dec (
    .cnt_i    (cnt),
    .step_i   (half_line_en_i),
    .gfx_i    (gfx_mode_i),
    .vsync_o  (vsync_o),
    .active_o (active_o),
    .hit_o    (hit)
  );

  vtg_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .flag_o (flag),
    .irq_o  (irq_o)
  );

  assign vcount_o    = cnt;
  assign rtc_flag_o  = flag[SRC_RTC];
  assign dend_flag_o = flag[SRC_DEND];
endmodule

// File: rtl/vtg_vertical_timing_chk.sv
module vtg_vertical_timing_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             half_line_en_i,
  input logic [1:0]       irq_en_i,
  input logic [1:0]       irq_clr_i,
  input logic             vsync_o,
  input logic             rtc_flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] vcount_o
);
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_line_en_i |=> $stable(vcount_o));
  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_line_en_i && vcount_o == CNT_W'(624)) |=> (vcount_o == '0));
  // R2
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcount_o <= CNT_W'(624));
  // R3
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (vcount_o == CNT_W'(564)));
  // R5
  rtc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_line_en_i && vcount_o == CNT_W'(199)) |=> rtc_flag_o);
  // R7
  rtc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i[0] && !(half_line_en_i && vcount_o == CNT_W'(199))) |=> !rtc_flag_o);
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 2'b00) |-> !irq_o);
endmodule

bind vtg_vertical_timing vtg_vertical_timing_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .half_line_en_i (half_line_en_i),
  .irq_en_i       (irq_en_i),
  .irq_clr_i      (irq_clr_i),
  .vsync_o        (vsync_o),
  .rtc_flag_o     (rtc_flag_o),
  .irq_o          (irq_o),
  .vcount_o       (vcount_o)
);

// File: tb/test_vtg_vertical_timing.sv
module test_vtg_vertical_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, gfx = 1'b1;
  logic [1:0] ie = 2'b00, clr = 2'b00;
  logic       vsync, active, rtc_f, dend_f, irq;
  logic [9:0] vcount;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_rtc = 0, m_dend = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vtg_vertical_timing i_vtg_vertical_timing (
    .clk_i(clk), .rst_ni(rst_n), .half_line_en_i(en), .gfx_mode_i(gfx),
    .irq_en_i(ie), .irq_clr_i(clr), .vsync_o(vsync), .active_o(active),
    .rtc_flag_o(rtc_f), .dend_flag_o(dend_f), .irq_o(irq), .vcount_o(vcount)
  );

  function automatic bit exp_vsync(int c);
    return (c >= 564) && (c <= 568);
  endfunction
  function automatic bit exp_active(int c, bit g);
    return c < (g ? 512 : 500);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (count model %0d)", req, act, exp, m_cnt);
    end
  endtask

  task automatic check_all();
    check("R1/R2 vcount", int'(vcount), m_cnt);
    check("R3 vsync", int'(vsync), int'(exp_vsync(m_cnt)));
    check("R4 active", int'(active), int'(exp_active(m_cnt, gfx)));
    check("R5/R7 rtc flag", int'(rtc_f), int'(m_rtc));
    check("R6/R7 dend flag", int'(dend_f), int'(m_dend));
    check("R8 irq", int'(irq), int'((m_rtc && ie[0]) || (m_dend && ie[1])));
  endtask

  task automatic step(bit e, bit g, logic [1:0] i, logic [1:0] c);
    bit set_r, set_d;
    @(negedge clk);
    en = e; gfx = g; ie = i; clr = c;
    @(posedge clk);
    #1;
    set_r = 0; set_d = 0;
    if (e) begin
      m_cnt = (m_cnt == 624) ? 0 : m_cnt + 1;
      set_r = (m_cnt == 200);
      set_d = (m_cnt == (g ? 512 : 500));
    end
    m_rtc  = set_r ? 1'b1 : (c[0] ? 1'b0 : m_rtc);
    m_dend = set_d ? 1'b1 : (c[1] ? 1'b0 : m_dend);
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    bit g;
    seed = 32'h5eed_0c70;
    void'($urandom(seed));
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset vcount", int'(vcount), 0);
    check("R9 reset vsync", int'(vsync), 0);
    check("R9 reset active", int'(active), 1);
    check("R9 reset flags", int'({rtc_f, dend_f}), 0);
    check("R9 reset irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 hold without enable
    repeat (5) step(0, 1, 2'b11, 2'b00);
    // R5 and R7: step to 200 with a coincident clear, set must win
    while (m_cnt != 199) step(1, 1, 2'b00, 2'b00);
    step(1, 1, 2'b01, 2'b01);
    check("R7 set over clear", int'(rtc_f), 1);
    step(0, 1, 2'b01, 2'b00);
    check("R8 irq from rtc", int'(irq), 1);
    step(0, 1, 2'b01, 2'b01);
    check("R7 rtc cleared", int'(rtc_f), 0);
    // R6 text mode end at 500, R4 live mode switch
    while (m_cnt != 499) step(1, 0, 2'b10, 2'b00);
    step(1, 0, 2'b10, 2'b00);
    check("R6 text end", int'(dend_f), 1);
    step(0, 1, 2'b10, 2'b10);
    check("R4 gfx active at 500", int'(active), 1);
    // R3 sync and R2 wrap
    while (m_cnt != 624) step(1, 1, 2'b00, 2'b00);
    step(1, 1, 2'b00, 2'b00);
    check("R2 wrap", int'(vcount), 0);

    // constrained random
    g = 1;
    for (int k = 0; k < 12000; k++) begin
      logic [1:0] i_r, c_r;
      if ($urandom_range(0, 299) == 0) g = ~g;
      i_r = 2'($urandom_range(0, 3));
      c_r = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      step($urandom_range(0, 3) != 0, g, i_r, c_r);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule